// File: doc/BRIEF.md
# Active Video Boundary Detector

This block locates the rectangle of real picture content inside an incoming video frame. It watches a pixel stream together with its horizontal and vertical sync signals. Horizontal positions are counted in pixel clocks from each hsync rising edge. Line numbers are counted in hsync rising edges from the vsync rising edge. Over one whole frame the block keeps the leftmost start, the rightmost end, the first line holding content and the first blank line after the content. A controller reads these four numbers to centre or size the picture.

A one-cycle start request arms the block. Measurement begins at the next vsync rising edge and covers exactly one frame. At the vsync rising edge that closes that frame, the four results and a no-content flag are loaded together, and a one-cycle done pulse follows. A mode input chooses how a pixel counts as content when horizontal extents are found. In level mode the pixel value must exceed a threshold. In gradient mode the step from the previous pixel must exceed it. A search-end input bounds the horizontal search.

Top module: `active_area_finder`

## Requirements
- R1: In level mode (grad_mode=0) a pixel is content when its value is strictly greater than thresh. h_start reports the smallest position of a content pixel, where the pixel clocked in the same cycle as an hsync rising edge is position 0 and each following clock adds 1.
- R2: h_end reports one more than the largest position of a content pixel.
- R3: In gradient mode (grad_mode=1) a pixel is content for the horizontal search when the absolute difference from the pixel of the previous clock is strictly greater than thresh. The pixel at position 0 is never content in this mode.
- R4: Pixels at positions greater than or equal to search_end are ignored by both the horizontal and the vertical search.
- R5: Over the measured frame, the earliest start and the latest end across all lines are reported, even when different lines supply them.
- R6: Line index 0 is the part of the frame from the vsync rising edge up to the next hsync rising edge. Each hsync rising edge adds 1 to the index. v_start is the index of the first line that holds a pixel strictly above thresh, and this test does not depend on grad_mode.
- R7: v_end is the index of the first line with no pixel above thresh that follows the last such line. If the line still open at the closing vsync rising edge holds content, v_end is that line's index plus 1.
- R8: A blank line followed by a line with content is not taken as the vertical end, and the search for the end resumes.
- R9: A start pulse while busy is 0 sets busy to 1 and arms measurement at the next vsync rising edge. The next vsync rising edge ends the frame. done is high for exactly one cycle, the cycle after that edge, and busy then returns to 0. A start pulse while busy is 1 is ignored.
- R10: If the measured frame has no content pixel of either kind, no_data is 1 and all four results are 0.
- R11: After reset all outputs are 0. Results and no_data change only together with done and hold until the next done.
- R12: When hsync and vsync rise in the same cycle, the open line is closed once and counted as part of the ending frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync, positive polarity |
| vsync | input | 1 | Vertical sync, positive polarity |
| pix | input | PIX_W | Pixel value |
| thresh | input | PIX_W | Detection threshold |
| grad_mode | input | 1 | 0: level test, 1: gradient test for horizontal search |
| search_end | input | POS_W | First horizontal position excluded from the search |
| start | input | 1 | One-cycle request to measure the next frame |
| busy | output | 1 | Armed or measuring |
| done | output | 1 | One-cycle pulse when results are loaded |
| no_data | output | 1 | No content found in the measured frame |
| h_start | output | POS_W | Leftmost content position |
| h_end | output | POS_W | Rightmost content position plus one |
| v_start | output | LINE_W | First content line index |
| v_end | output | LINE_W | First blank line index after content |

## Verification
The frame-closing vsync rising edge can arrive in the same cycle as an hsync rising edge. In that cycle the open line must be closed and judged and the frame must be finalised. The bench provokes this with a vector whose sync lines rise together and whose content reaches the last line. Because the last line is then closed only by the coincident edge, the expected v_end is that line's index plus one, and a missed or doubled line close shows up directly in v_end.

// File: rtl/aab_pkg.sv
package aab_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_MEAS  = 2'd2
    } aab_state_e;

endpackage

// File: rtl/aab_edge.sv
module aab_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    output logic [N-1:0] rise
);

    logic [N-1:0] level_d, level_q;

    always_comb begin
        level_d = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise[i] = level[i] & ~level_q[i];
    end

endmodule

// File: rtl/aab_classify.sv
module aab_classify #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix,
    input  logic [PIX_W-1:0] thresh,
    input  logic             grad_mode,
    input  logic             line_first,
    output logic             hit_sel,
    output logic             hit_lvl
);

    logic [PIX_W-1:0] prev_d, prev_q;
    logic [PIX_W-1:0] step;
    logic             hit_grad;

    always_comb begin
        prev_d   = pix;
        step     = (pix > prev_q) ? (pix - prev_q) : (prev_q - pix);
        hit_lvl  = (pix > thresh);
        hit_grad = !line_first && (step > thresh);
        hit_sel  = grad_mode ? hit_grad : hit_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/aab_vtrack.sv
module aab_vtrack #(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              lvl_hit,
    input  logic              close,
    input  logic [LINE_W-1:0] line_idx,
    output logic              res_seen,
    output logic [LINE_W-1:0] res_vstart,
    output logic [LINE_W-1:0] res_vend
);

    typedef struct packed {
        logic              line_lvl;
        logic              seen;
        logic [LINE_W-1:0] vstart;
        logic              cand_ok;
        logic [LINE_W-1:0] cand;
    } vt_t;

    vt_t vt_d, vt_q;

    always_comb begin
        vt_d = vt_q;
        if (clear) begin
            vt_d = '0;
        end else if (close) begin
            if (vt_q.line_lvl) begin
                if (!vt_q.seen) begin
                    vt_d.vstart = line_idx;
                    vt_d.seen   = 1'b1;
                end
                vt_d.cand_ok = 1'b0;
            end else if (vt_q.seen && !vt_q.cand_ok) begin
                vt_d.cand    = line_idx;
                vt_d.cand_ok = 1'b1;
            end
            vt_d.line_lvl = lvl_hit;
        end else if (lvl_hit) begin
            vt_d.line_lvl = 1'b1;
        end

        res_seen   = vt_d.seen;
        res_vstart = vt_d.seen ? vt_d.vstart : '0;
        if (!vt_d.seen)      res_vend = '0;
        else if (vt_d.cand_ok) res_vend = vt_d.cand;
        else                 res_vend = line_idx + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vt_q <= '0;
        else        vt_q <= vt_d;
    end

endmodule

// File: rtl/active_area_finder.sv
module active_area_finder
    import aab_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int POS_W  = 12,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    input  logic [PIX_W-1:0]  pix,
    input  logic [PIX_W-1:0]  thresh,
    input  logic              grad_mode,
    input  logic [POS_W-1:0]  search_end,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              no_data,
    output logic [POS_W-1:0]  h_start,
    output logic [POS_W-1:0]  h_end,
    output logic [LINE_W-1:0] v_start,
    output logic [LINE_W-1:0] v_end
);

    localparam logic [POS_W-1:0]  POS_MAX  = {POS_W{1'b1}};
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    typedef struct packed {
        aab_state_e        st;
        logic [POS_W-1:0]  hcnt;
        logic [LINE_W-1:0] vcnt;
        logic              h_seen;
        logic [POS_W-1:0]  hmin;
        logic [POS_W-1:0]  hmax;
        logic              done;
        logic              no_data;
        logic [POS_W-1:0]  r_hs;
        logic [POS_W-1:0]  r_he;
        logic [LINE_W-1:0] r_vs;
        logic [LINE_W-1:0] r_ve;
    } regs_t;

    regs_t r_d, r_q;

    logic [1:0]        sync_rise;
    logic              hs_rise, vs_rise;
    logic [POS_W-1:0]  hpos;
    logic              in_meas, pix_live;
    logic              hit_sel, hit_lvl;
    logic              v_clear, v_close;
    logic              res_seen;
    logic [LINE_W-1:0] res_vstart, res_vend;

    aab_edge #(.N(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level ({vsync, hsync}),
        .rise  (sync_rise)
    );

    assign hs_rise = sync_rise[0];
    assign vs_rise = sync_rise[1];

    always_comb begin
        if (hs_rise)              hpos = '0;
        else if (r_q.hcnt == POS_MAX) hpos = POS_MAX;
        else                      hpos = r_q.hcnt + 1'b1;
        in_meas  = (r_q.st == ST_MEAS);
        pix_live = in_meas && !vs_rise && (hpos < search_end);
        v_clear  = (r_q.st == ST_ARMED) && vs_rise;
        v_close  = in_meas && (hs_rise || vs_rise);
    end

    aab_classify #(.PIX_W(PIX_W)) u_class (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix        (pix),
        .thresh     (thresh),
        .grad_mode  (grad_mode),
        .line_first (hs_rise),
        .hit_sel    (hit_sel),
        .hit_lvl    (hit_lvl)
    );

    aab_vtrack #(.LINE_W(LINE_W)) u_vtrack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (v_clear),
        .lvl_hit    (pix_live && hit_lvl),
        .close      (v_close),
        .line_idx   (r_q.vcnt),
        .res_seen   (res_seen),
        .res_vstart (res_vstart),
        .res_vend   (res_vend)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.hcnt = hpos;

        if (vs_rise)                      r_d.vcnt = '0;
        else if (hs_rise && r_q.vcnt != LINE_MAX) r_d.vcnt = r_q.vcnt + 1'b1;

        if (pix_live && hit_sel) begin
            if (!r_q.h_seen || hpos < r_q.hmin)          r_d.hmin = hpos;
            if (!r_q.h_seen || (hpos + 1'b1) > r_q.hmax) r_d.hmax = hpos + 1'b1;
            r_d.h_seen = 1'b1;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) r_d.st = ST_ARMED;
            end
            ST_ARMED: begin
                if (vs_rise) begin
                    r_d.st     = ST_MEAS;
                    r_d.h_seen = 1'b0;
                    r_d.hmin   = '0;
                    r_d.hmax   = '0;
                end
            end
            ST_MEAS: begin
                if (vs_rise) begin
                    r_d.st      = ST_IDLE;
                    r_d.done    = 1'b1;
                    r_d.r_hs    = r_q.h_seen ? r_q.hmin : '0;
                    r_d.r_he    = r_q.h_seen ? r_q.hmax : '0;
                    r_d.r_vs    = res_vstart;
                    r_d.r_ve    = res_vend;
                    r_d.no_data = !r_q.h_seen && !res_seen;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign no_data = r_q.no_data;
    assign h_start = r_q.r_hs;
    assign h_end   = r_q.r_he;
    assign v_start = r_q.r_vs;
    assign v_end   = r_q.r_ve;

endmodule

// File: rtl/aab_checker.sv
module aab_checker #(
    parameter int POS_W  = 12,
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vsync,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              no_data,
    input logic [POS_W-1:0]  h_start,
    input logic [POS_W-1:0]  h_end,
    input logic [LINE_W-1:0] v_start,
    input logic [LINE_W-1:0] v_end
);

    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_after_vsync_edge: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(vsync) && !$past(vsync, 2)));

    a_r9_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r10_nodata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        no_data |-> (h_start == '0 && h_end == '0 && v_start == '0 && v_end == '0));

    a_r2_h_order: assert property (@(posedge clk) disable iff (!rst_n)
        (h_end != '0) |-> (h_end > h_start));

    a_r7_v_order: assert property (@(posedge clk) disable iff (!rst_n)
        (v_end != '0) |-> (v_end > v_start));

    a_r11_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({no_data, h_start, h_end, v_start, v_end}) |-> done);

endmodule

bind active_area_finder aab_checker #(.POS_W(POS_W), .LINE_W(LINE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .vsync   (vsync),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .no_data (no_data),
    .h_start (h_start),
    .h_end   (h_end),
    .v_start (v_start),
    .v_end   (v_end)
);

// File: tb/active_area_finder_tb.sv
`timescale 1ns/1ps
module active_area_finder_tb;

    localparam int PIX_W  = 8;
    localparam int POS_W  = 12;
    localparam int LINE_W = 11;
    localparam int LL     = 40;
    localparam int NROWS  = 8;
    localparam int NV     = 10;

    // fields: grad thr lim x0 x1 y0 y1 val hole same stag | hs he vs ve nd
    localparam int TBL [0:NV-1][0:15] = '{
        '{0, 16, 40, 10, 20, 2, 6, 100, 0, 0, 0,  10, 20, 2, 6, 0},
        '{1, 16, 40, 10, 20, 2, 6, 100, 0, 0, 0,  10, 21, 2, 6, 0},
        '{0, 16, 35, 30, 40, 3, 9, 100, 0, 0, 0,  30, 35, 3, 9, 0},
        '{0, 16, 40,  8, 12, 2, 8, 100, 4, 0, 0,   8, 12, 2, 8, 0},
        '{0, 16, 40, 10, 20, 2, 6,  16, 0, 0, 0,   0,  0, 0, 0, 1},
        '{0, 16, 40,  4, 38, 5, 9, 100, 0, 1, 0,   4, 38, 5, 9, 0},
        '{1, 16, 15,  6, 30, 1, 3, 100, 0, 0, 0,   6,  7, 1, 3, 0},
        '{0, 16, 40, 10, 20, 2, 6, 100, 0, 0, 5,  10, 25, 2, 6, 0},
        '{1, 16, 40, 20, 40, 2, 4, 100, 0, 0, 0,  20, 21, 2, 4, 0},
        '{0, 16, 40,  5,  6, 8, 9,  17, 0, 0, 0,   5,  6, 8, 9, 0}
    };
    localparam string TAG [0:NV-1] = '{"R1", "R3", "R4", "R8", "R10",
                                       "R12", "R3 R4", "R5", "R3", "R1"};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hsync = 1'b0, vsync = 1'b0, grad_mode = 1'b0, start = 1'b0;
    logic [PIX_W-1:0]  pix = '0, thresh = '0;
    logic [POS_W-1:0]  search_end = '0;
    logic              busy, done, no_data;
    logic [POS_W-1:0]  h_start, h_end;
    logic [LINE_W-1:0] v_start, v_end;

    always #10 clk = ~clk;

    active_area_finder #(.PIX_W(PIX_W), .POS_W(POS_W), .LINE_W(LINE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .pix(pix),
        .thresh(thresh), .grad_mode(grad_mode), .search_end(search_end),
        .start(start), .busy(busy), .done(done), .no_data(no_data),
        .h_start(h_start), .h_end(h_end), .v_start(v_start), .v_end(v_end)
    );

    int checks = 0, fails = 0, cyc = 0;
    int cap_n = 0, cap_cyc = 0, vs_cyc = 0;
    int cap_hs, cap_he, cap_vs, cap_ve, cap_nd;
    bit start_req = 0, mid_start = 0, finished = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input bit hs, input bit vs, input int px);
        @(negedge clk);
        cyc++;
        if (done) begin
            cap_n++; cap_cyc = cyc;
            cap_hs = h_start; cap_he = h_end; cap_vs = v_start;
            cap_ve = v_end;   cap_nd = no_data;
        end
        if (vs && !vsync) vs_cyc = cyc;
        hsync = hs; vsync = vs; pix = px[PIX_W-1:0];
        start = start_req; start_req = 0;
    endtask

    function automatic int pixval(input int v, input int row, input int col);
        int xs, xe;
        if (TBL[v][8] == row) return 0;
        if (row < TBL[v][5] || row >= TBL[v][6]) return 0;
        xs = TBL[v][3] + ((row % 2 == 1) ? TBL[v][10] : 0);
        xe = TBL[v][4] + ((row % 2 == 1) ? TBL[v][10] : 0);
        return (col >= xs && col < xe) ? TBL[v][7] : 0;
    endfunction

    task automatic vs_line(input int same);
        for (int c = 0; c < LL; c++) begin
            if (same != 0) step(c < 2, c < 5, 0);
            else           step(c < 2, (c >= 5 && c < 10), 0);
        end
    endtask

    task automatic send_frame(input int v);
        vs_line(TBL[v][9]);
        for (int r = 1; r <= NROWS; r++) begin
            for (int c = 0; c < LL; c++) begin
                if (mid_start && r == 3 && c == 20) start_req = 1;
                step(c < 2, 0, pixval(v, r, c));
            end
        end
    endtask

    task automatic set_cfg(input int v);
        grad_mode  = TBL[v][0][0];
        thresh     = TBL[v][1][PIX_W-1:0];
        search_end = TBL[v][2][POS_W-1:0];
    endtask

    task automatic measure(input int v);
        int n0;
        n0 = cap_n;
        start_req = 1;
        step(0, 0, 0);
        step(0, 0, 0);
        chk("R9 busy after start", busy, 1);
        send_frame(v);
        vs_line(TBL[v][9]);
        step(0, 0, 0);
        chk($sformatf("R9 done count vec%0d", v), cap_n - n0, 1);
        chk($sformatf("R9 done timing vec%0d", v), cap_cyc, vs_cyc + 1);
        chk($sformatf("%s R1 R5 h_start vec%0d", TAG[v], v), cap_hs, TBL[v][11]);
        chk($sformatf("%s R2 h_end vec%0d", TAG[v], v), cap_he, TBL[v][12]);
        chk($sformatf("%s R6 v_start vec%0d", TAG[v], v), cap_vs, TBL[v][13]);
        chk($sformatf("%s R7 v_end vec%0d", TAG[v], v), cap_ve, TBL[v][14]);
        chk($sformatf("%s R10 no_data vec%0d", TAG[v], v), cap_nd, TBL[v][15]);
        chk("R9 busy cleared", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset busy", busy, 0);
        chk("R11 reset done", done, 0);
        chk("R11 reset no_data", no_data, 0);
        chk("R11 reset results", int'(h_start) + int'(h_end) + int'(v_start) + int'(v_end), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            set_cfg(v);
            measure(v);
        end

        // R9: start during measurement is ignored
        set_cfg(0);
        mid_start = 1;
        measure(0);
        mid_start = 0;

        // R9 and R11: no start, frame passes without done, results hold
        begin
            int n0;
            n0 = cap_n;
            set_cfg(2);
            send_frame(2);
            vs_line(0);
            step(0, 0, 0);
            chk("R9 no done without start", cap_n - n0, 0);
            chk("R9 stays idle", busy, 0);
            chk("R11 h_start held", h_start, 10);
            chk("R11 v_end held", v_end, 6);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule